// File: doc/BRIEF.md
# Memory-Mapped General-Purpose I/O Port

This block is a general-purpose I/O port of `W` pins behind a minimal word-addressed register bus. An output latch holds the value driven on each pin. A direction latch decides, pin by pin, whether the output enable is active. Software can load the output latch in one write. It can also raise or drop chosen bits atomically by writing a one-hot or multi-hot mask to a set word or a clear word. In that case no read-modify-write sequence is needed, and no lock is needed around it.

Pin inputs pass through a two-stage synchronizer before they appear in the data word. Three choices are fixed at elaboration: the polarity of the direction word, whether pin `n` is carried on bit `n` or on bit `W-1-n`, and whether bus words are byte-swapped on the way in and out. Each pin is brought out as separate input, output and output-enable wires, so a pad ring or another block can combine them.

Top module: `gpio_mmio_port`

## Requirements
- R1: After a cycle with `rst` high, the output latch is all zeros and every pin is an input (`pin_oe` all zeros). The direction word reads as all zeros when `DIR_OUT`=1 and as all ones when `DIR_OUT`=0.
- R2: A write to word address 0 (data) loads the whole output latch. `pin_out` shows the new value after the clock edge that takes the write.
- R3: A write to word address 1 (set) sets the latch bits where the written word holds ones. Bits where it holds zeros are left as they were.
- R4: A write to word address 2 (clear) clears the latch bits where the written word holds ones. Bits where it holds zeros are left as they were. Reading address 2 returns zero.
- R5: Reading word address 1 returns the current output latch.
- R6: Reading word address 0 returns `pin_in` through a two-flop synchronizer. A change on `pin_in` appears on `bus_rdata` after the second rising edge, and not after the first.
- R7: Word address 3 holds the direction word, which can be written and read back. With `DIR_OUT`=1 a one bit makes that pin an output. With `DIR_OUT`=0 a one bit makes that pin an input. `pin_oe[n]` is high exactly when pin `n` is an output.
- R8: `pin_out` always shows the output latch, whatever the direction. With no write, `pin_out` and `pin_oe` hold their values.
- R9: With `REV_BITS`=1, pin `n` is carried on register bit `W-1-n` for reads and writes of every word. With `REV_BITS`=0, pin `n` is carried on bit `n`.
- R10: With `BYTE_SWAP`=1, bus words are byte-reversed on both write and read. Byte swap together with `W`=64 is refused at elaboration, and so is any `W` other than 8, 16, 32 or 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Word address: 0 data, 1 set, 2 clear, 3 direction |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data of the addressed word (combinational) |
| pin_in | input | W | Pin levels from outside, asynchronous |
| pin_out | output | W | Output latch, in pin order |
| pin_oe | output | W | Output enable per pin |

## Verification
The bench targets the masked set and clear words with zero masks and with masks that overlap bits already in the wanted state. A design that treated those words as plain stores would wipe unrelated pins. It samples the data word one edge and two edges after an input change, to catch a synchronizer that is missing a stage or has one too many. A second instance combines inverted direction polarity, reversed bit order and byte swap, using a bus value whose expected pin is worked out by hand. An implementation that applies the swap on one path only, or that forgets the reversal on readback, returns a word that differs from the one written.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    // Word addresses on the register bus.
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_DIR  = 2'd3
    } gpio_reg_e;

    // One-hot write strobes derived from the bus.
    typedef struct packed {
        logic wr_data;
        logic wr_set;
        logic wr_clr;
        logic wr_dir;
    } gpio_wr_s;

    function automatic gpio_wr_s decode_write(input logic we, input gpio_reg_e sel);
        gpio_wr_s s;
        s.wr_data = we && (sel == REG_DATA);
        s.wr_set  = we && (sel == REG_SET);
        s.wr_clr  = we && (sel == REG_CLR);
        s.wr_dir  = we && (sel == REG_DIR);
        return s;
    endfunction

    function automatic bit width_supported(input int w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

endpackage

// File: rtl/gpio_lane.sv
// Bus-word <-> pin-vector conversion. Byte swap and bit reversal are each
// self-inverse and commute, so one instance type serves both directions.
module gpio_lane #(
    parameter int W         = 32,
    parameter bit REV_BITS  = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / 8;

    logic [W-1:0] swapped;

    generate
        if (BYTE_SWAP) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                assign swapped[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
            end
        end else begin : g_noswap
            assign swapped = din;
        end

        if (REV_BITS) begin : g_rev
            for (genvar n = 0; n < W; n++) begin : g_bit
                assign dout[n] = swapped[W-1-n];
            end
        end else begin : g_norev
            assign dout = swapped;
        end
    endgenerate
endmodule

// File: rtl/gpio_sync.sv
// Two-stage synchronizer for the asynchronous pin inputs.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        stage1 <= async_in;
        stage2 <= stage1;
    end

    assign sync_out = stage2;
endmodule

// File: rtl/gpio_regs.sv
// Output latch and direction latch, both kept in pin order.
module gpio_regs
    import gpio_mmio_pkg::*;
#(
    parameter int W       = 32,
    parameter bit DIR_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  gpio_wr_s     wr,
    input  logic [W-1:0] wval,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q
);
    // Reset value of the direction latch: all pins inputs.
    localparam logic [W-1:0] DIR_RST = DIR_OUT ? '0 : '1;

    logic [W-1:0] out_d;

    always_comb begin
        out_d = out_q;
        if (wr.wr_data)
            out_d = wval;
        else if (wr.wr_set)
            out_d = out_q | wval;
        else if (wr.wr_clr)
            out_d = out_q & ~wval;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= DIR_RST;
        end else begin
            out_q <= out_d;
            if (wr.wr_dir)
                dir_q <= wval;
        end
    end
endmodule

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port
    import gpio_mmio_pkg::*;
#(
    parameter int W         = 32,
    parameter bit DIR_OUT   = 1'b1,
    parameter bit REV_BITS  = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   bus_addr,
    input  logic         bus_we,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    generate
        if (!width_supported(W)) begin : g_bad_width
            $error("gpio_mmio_port: width must be 8, 16, 32 or 64");
        end
        if (BYTE_SWAP && (W == 64)) begin : g_bad_swap
            $error("gpio_mmio_port: byte swap is not available at width 64");
        end
    endgenerate

    gpio_reg_e    sel;
    gpio_wr_s     wr;
    logic [W-1:0] wval_pins;
    logic [W-1:0] in_sync;
    logic [W-1:0] out_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] rd_pins;

    assign sel = gpio_reg_e'(bus_addr);
    assign wr  = decode_write(bus_we, sel);

    gpio_lane #(.W(W), .REV_BITS(REV_BITS), .BYTE_SWAP(BYTE_SWAP)) u_lane_wr (
        .din  (bus_wdata),
        .dout (wval_pins)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk      (clk),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    gpio_regs #(.W(W), .DIR_OUT(DIR_OUT)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .wval  (wval_pins),
        .out_q (out_q),
        .dir_q (dir_q)
    );

    always_comb begin
        unique case (sel)
            REG_DATA: rd_pins = in_sync;
            REG_SET:  rd_pins = out_q;
            REG_CLR:  rd_pins = '0;
            REG_DIR:  rd_pins = dir_q;
            default:  rd_pins = '0;
        endcase
    end

    gpio_lane #(.W(W), .REV_BITS(REV_BITS), .BYTE_SWAP(BYTE_SWAP)) u_lane_rd (
        .din  (rd_pins),
        .dout (bus_rdata)
    );

    assign pin_out = out_q;
    assign pin_oe  = DIR_OUT ? dir_q : ~dir_q;
endmodule

// File: rtl/gpio_mmio_port_chk.sv
module gpio_mmio_port_chk #(
    parameter int W       = 32,
    parameter bit DIR_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   bus_addr,
    input logic         bus_we,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pin_out == '0) && (pin_oe == '0)); // R1

    AST_SET_NEVER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd1) |=> ((pin_out & $past(pin_out)) == $past(pin_out))); // R3

    AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd2) |=> ((pin_out & ~$past(pin_out)) == '0)); // R4

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd2) |-> (bus_rdata == '0)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe))); // R8

    AST_DIR_MATCHES_OE: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> ($countones(bus_rdata) ==
            (DIR_OUT ? $countones(pin_oe) : (W - $countones(pin_oe))))); // R7
endmodule

bind gpio_mmio_port gpio_mmio_port_chk #(.W(W), .DIR_OUT(DIR_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_mmio_port_test.sv
module gpio_mmio_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {addr, wdata, expected pin_out, expected pin_oe}
    localparam logic [97:0] VEC [NVEC] = '{
        {2'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 32'h0000_0000}, // R2
        {2'd1, 32'h0000_F0F0, 32'hA5A5_FFFF, 32'h0000_0000}, // R3
        {2'd2, 32'hA500_0000, 32'h00A5_FFFF, 32'h0000_0000}, // R4
        {2'd3, 32'hFFFF_0000, 32'h00A5_FFFF, 32'hFFFF_0000}, // R7 R8
        {2'd2, 32'h0000_00FF, 32'h00A5_FF00, 32'hFFFF_0000}, // R4
        {2'd1, 32'h0000_0000, 32'h00A5_FF00, 32'hFFFF_0000}, // R3 zero mask
        {2'd2, 32'h0000_0000, 32'h00A5_FF00, 32'hFFFF_0000}, // R4 zero mask
        {2'd0, 32'h1234_5678, 32'h1234_5678, 32'hFFFF_0000}  // R2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    logic [1:0]  a_addr = '0;
    logic        a_we = 1'b0;
    logic [15:0] a_wdata = '0;
    logic [15:0] a_rdata;
    logic [15:0] a_pin_in = '0;
    logic [15:0] a_pin_out;
    logic [15:0] a_pin_oe;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mmio_port #(.W(32), .DIR_OUT(1'b1), .REV_BITS(1'b0), .BYTE_SWAP(1'b0)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    gpio_mmio_port #(.W(16), .DIR_OUT(1'b0), .REV_BITS(1'b1), .BYTE_SWAP(1'b1)) uut_alt (
        .clk(clk), .rst(rst), .bus_addr(a_addr), .bus_we(a_we), .bus_wdata(a_wdata),
        .bus_rdata(a_rdata), .pin_in(a_pin_in), .pin_out(a_pin_out), .pin_oe(a_pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_main(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr_alt(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        a_addr = a; a_wdata = d; a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        addr = 2'd3; #1;
        check("R1 dir dirout", rdata, 32'h0);
        check("R1 alt pin_oe", {16'h0, a_pin_oe}, 32'h0);
        a_addr = 2'd3; #1;
        check("R1 alt dir dirin", {16'h0, a_rdata}, 32'h0000_FFFF);

        // Table walk: R2 R3 R4 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            wr_main(VEC[i][97:96], VEC[i][95:64]);
            check("R2/R3/R4/R8 table pin_out", pin_out, VEC[i][63:32]);
            check("R7 table pin_oe", pin_oe, VEC[i][31:0]);
        end

        // R5 set word readback, R4 clear reads zero, R7 dir readback
        addr = 2'd1; #1;
        check("R5 set readback", rdata, 32'h1234_5678);
        addr = 2'd2; #1;
        check("R4 clear reads zero", rdata, 32'h0);
        addr = 2'd3; #1;
        check("R7 dir readback", rdata, 32'hFFFF_0000);

        // R6 two-stage input path
        addr = 2'd0;
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R6 not after one edge", rdata, 32'h0);
        @(negedge clk);
        check("R6 after two edges", rdata, 32'hDEAD_BEEF);

        // R9 R10 reversed, byte swapped, inverted-polarity instance
        wr_alt(2'd0, 16'h0102);
        check("R9 R10 alt data write", {16'h0, a_pin_out}, 32'h0000_8040);
        a_addr = 2'd1; #1;
        check("R9 R10 alt set readback", {16'h0, a_rdata}, 32'h0000_0102);
        wr_alt(2'd3, 16'h00FF);
        check("R7 alt dirin oe", {16'h0, a_pin_oe}, 32'h0000_FF00);
        a_addr = 2'd3; #1;
        check("R7 alt dir readback", {16'h0, a_rdata}, 32'h0000_00FF);
        wr_alt(2'd1, 16'h0001);
        check("R3 R10 alt set", {16'h0, a_pin_out}, 32'h0000_80C0);
        wr_alt(2'd2, 16'h0200);
        check("R4 R9 alt clear of low pin", {16'h0, a_pin_out}, 32'h0000_80C0);
        wr_alt(2'd2, 16'h0002);
        check("R4 R9 alt clear", {16'h0, a_pin_out}, 32'h0000_8080);
        a_addr = 2'd0;
        a_pin_in = 16'h0001;
        repeat (2) @(negedge clk);
        check("R6 R9 R10 alt input read", {16'h0, a_rdata}, 32'h0000_0080);

        // R1 reset again after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 pin_out after reset", pin_out, 32'h0);
        check("R1 pin_oe after reset", pin_oe, 32'h0);
        check("R1 alt pin_out after reset", {16'h0, a_pin_out}, 32'h0);

        finish_run();
    end
endmodule